// File: doc/BRIEF.md
# PWM Channel Enable and Interrupt Register Block

This block is the global control front end of a multi-channel pulse-width modulator. Software uses it to switch channels on and off and to choose which channels may interrupt. It also collects the end-of-period events that each channel's counter reports, and lets software acknowledge them. The counters, the clock dividers and the pin muxing sit in neighbouring logic. That logic consumes the per-channel enable outputs and supplies the one-cycle `period_end` pulses.

Enable state and interrupt mask state change only through paired write-one-to-set and write-one-to-clear registers. Channel i is always bit i of the data word, so one write can touch any group of channels and leaves the others alone. Pending events are sticky. Reading the interrupt status register returns the pending bits and clears them in the same access. An event that arrives in the cycle of that read stays pending. The single interrupt line is high whenever a pending channel is also unmasked.

The block has no sequencing state machine. Each bus cycle is decoded into one register selection, held in an enumerated type with the values SEL_MODE, SEL_ENA, SEL_DIS, SEL_STAT, SEL_IEN, SEL_IDIS, SEL_IMASK, SEL_ISR and SEL_NONE. A `unique case` on that selection steers the write strobes and the read multiplexer. Between accesses the block rests with no transition. Reads return data one cycle later from a holding register.

Top module: `pwm_glob_regs`

## Requirements
- R1: After reset, all channel enables, mask bits and pending bits are zero. `irq` is low and `bus_rdata` is zero.
- R2: A write to offset 0x04 sets every enable bit i whose write-data bit i is 1. A write to offset 0x08 clears every enable bit i whose write-data bit i is 1. Zero data bits change nothing. `ch_enable` shows the new value from the cycle after the write.
- R3: A write to offset 0x10 sets mask bits, and a write to offset 0x14 clears them, with the same write-one rule as R2. A read of offset 0x18 returns the current mask in bits NUM_CH-1:0.
- R4: A high `period_end[i]` in any cycle makes pending bit i 1 from the next cycle onward. This does not depend on the mask or the enable state.
- R5: A read of offset 0x1C returns the pending bits as they were before the access and clears them. An event arriving in the same cycle as that read remains pending.
- R6: `irq` is 1 exactly when some channel is both pending and unmasked. It is driven from registered state, with no input-to-output path.
- R7: Offset 0x00 is a full-width read/write mode register.
- R8: A read of offset 0x0C returns the enable bits. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read. Bits at or above NUM_CH read 0. Unmapped offsets read 0. Writes to 0x0C, 0x18, 0x1C and unmapped offsets change nothing. When `bus_wr` and `bus_rd` are both high, the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wdata | input | DATA_W | Write data, channel i in bit i |
| bus_rdata | output | DATA_W | Read data, valid from the cycle after a read |
| period_end | input | NUM_CH | One pulse per channel at the end of each period |
| ch_enable | output | NUM_CH | Enable for each channel counter |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `period_end` and the bus strobes are synchronous to `clk` and change away from its rising edge. They also assume that a read and an event on the same channel can coincide, and the properties on pending state treat that case explicitly. The stimulus drives every input on the falling edge. It uses single-cycle strobes with all other bus inputs held. It deliberately places an event in the same cycle as a status read to exercise the overlap case.

// File: rtl/pwm_glob_pkg.sv
package pwm_glob_pkg;

    localparam int OFF_MODE  = 'h00;
    localparam int OFF_ENA   = 'h04;
    localparam int OFF_DIS   = 'h08;
    localparam int OFF_STAT  = 'h0C;
    localparam int OFF_IEN   = 'h10;
    localparam int OFF_IDIS  = 'h14;
    localparam int OFF_IMASK = 'h18;
    localparam int OFF_ISR   = 'h1C;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_ENA,
        SEL_DIS,
        SEL_STAT,
        SEL_IEN,
        SEL_IDIS,
        SEL_IMASK,
        SEL_ISR
    } reg_sel_e;

endpackage

// File: rtl/pwm_glob_decode.sv
module pwm_glob_decode
    import pwm_glob_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if      (addr == ADDR_W'(OFF_MODE))  sel = SEL_MODE;
        else if (addr == ADDR_W'(OFF_ENA))   sel = SEL_ENA;
        else if (addr == ADDR_W'(OFF_DIS))   sel = SEL_DIS;
        else if (addr == ADDR_W'(OFF_STAT))  sel = SEL_STAT;
        else if (addr == ADDR_W'(OFF_IEN))   sel = SEL_IEN;
        else if (addr == ADDR_W'(OFF_IDIS))  sel = SEL_IDIS;
        else if (addr == ADDR_W'(OFF_IMASK)) sel = SEL_IMASK;
        else if (addr == ADDR_W'(OFF_ISR))   sel = SEL_ISR;
        else                                 sel = SEL_NONE;
    end

endmodule

// File: rtl/pwm_glob_setclr.sv
module pwm_glob_setclr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);

    logic [W-1:0] q_next;

    always_comb begin
        q_next = q;
        if (set_stb) q_next = q_next | bits;
        if (clr_stb) q_next = q_next & ~bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

endmodule

// File: rtl/pwm_glob_pending.sv
module pwm_glob_pending #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ack_stb,
    input  logic [W-1:0] events,
    output logic [W-1:0] q
);

    logic [W-1:0] keep;

    always_comb keep = ack_stb ? '0 : q;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= keep | events;
    end

endmodule

// File: rtl/pwm_glob_regs.sv
module pwm_glob_regs
    import pwm_glob_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] period_end,
    output logic [NUM_CH-1:0] ch_enable,
    output logic              irq
);

    reg_sel_e          sel;
    logic              rd_eff;
    logic              ena_stb, dis_stb, ien_stb, idis_stb, mode_stb, ack_stb;
    logic [NUM_CH-1:0] ch_bits;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] pend_q;
    logic [DATA_W-1:0] mode_q;
    logic [DATA_W-1:0] rd_mux;

    function automatic logic [DATA_W-1:0] widen(input logic [NUM_CH-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_CH-1:0] = v;
        return r;
    endfunction

    assign ch_bits = bus_wdata[NUM_CH-1:0];
    assign rd_eff  = bus_rd && !bus_wr;

    pwm_glob_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        ena_stb  = 1'b0;
        dis_stb  = 1'b0;
        ien_stb  = 1'b0;
        idis_stb = 1'b0;
        mode_stb = 1'b0;
        ack_stb  = 1'b0;
        rd_mux   = '0;
        unique case (sel)
            SEL_MODE:  begin mode_stb = bus_wr; rd_mux = mode_q;           end
            SEL_ENA:   ena_stb  = bus_wr;
            SEL_DIS:   dis_stb  = bus_wr;
            SEL_STAT:  rd_mux   = widen(ch_enable);
            SEL_IEN:   ien_stb  = bus_wr;
            SEL_IDIS:  idis_stb = bus_wr;
            SEL_IMASK: rd_mux   = widen(mask_q);
            SEL_ISR:   begin ack_stb = rd_eff; rd_mux = widen(pend_q);    end
            SEL_NONE:  rd_mux   = '0;
            default:   rd_mux   = '0;
        endcase
    end

    pwm_glob_setclr #(.W(NUM_CH)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (ena_stb),
        .clr_stb (dis_stb),
        .bits    (ch_bits),
        .q       (ch_enable)
    );

    pwm_glob_setclr #(.W(NUM_CH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (ien_stb),
        .clr_stb (idis_stb),
        .bits    (ch_bits),
        .q       (mask_q)
    );

    pwm_glob_pending #(.W(NUM_CH)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_stb (ack_stb),
        .events  (period_end),
        .q       (pend_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            bus_rdata <= '0;
        end else begin
            if (mode_stb) mode_q    <= bus_wdata;
            if (rd_eff)   bus_rdata <= rd_mux;
        end
    end

    assign irq = |(pend_q & mask_q);

endmodule

// File: rtl/pwm_glob_regs_chk.sv
module pwm_glob_regs_chk
    import pwm_glob_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] period_end,
    input logic [NUM_CH-1:0] ch_enable,
    input logic              irq,
    input logic [NUM_CH-1:0] pend_q
);

    logic wr_ena, wr_dis, rd_isr;
    assign wr_ena = bus_wr && (bus_addr == ADDR_W'(OFF_ENA));
    assign wr_dis = bus_wr && (bus_addr == ADDR_W'(OFF_DIS));
    assign rd_isr = bus_rd && !bus_wr && (bus_addr == ADDR_W'(OFF_ISR));

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ch_enable == '0 && pend_q == '0 && bus_rdata == '0));

    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ena |=> ((ch_enable & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

    p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dis |=> ((ch_enable & $past(bus_wdata[NUM_CH-1:0])) == '0));

    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ena || wr_dis) |=> $stable(ch_enable));

    p_event_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end != '0) |=> ((pend_q & $past(period_end)) == $past(period_end)));

    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_isr && period_end == '0) |=> (pend_q == '0));

    p_irq_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_isr && period_end == '0) |=> !irq);

    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr) |=> $stable(bus_rdata));

endmodule

bind pwm_glob_regs pwm_glob_regs_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .period_end (period_end),
    .ch_enable  (ch_enable),
    .irq        (irq),
    .pend_q     (pend_q)
);

// File: tb/pwm_glob_regs_test.sv
module pwm_glob_regs_test;

    localparam int NCH = 4;
    localparam int AW  = 8;
    localparam int DW  = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NCH-1:0] period_end = '0;
    logic [NCH-1:0] ch_enable;
    logic          irq;

    int n_checks = 0;
    int n_bad    = 0;

    // behavioural reference state
    int unsigned m_mode = 0, m_en = 0, m_mask = 0, m_pend = 0, m_rdata = 0;
    bit m_live = 0;

    pwm_glob_regs #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .period_end(period_end), .ch_enable(ch_enable), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model: advances on each rising edge
    always @(posedge clk) begin
        int unsigned lim, wd;
        bit ack;
        lim = (1 << NCH) - 1;
        wd  = bus_wdata;
        ack = 0;
        if (!rst_n) begin
            m_mode = 0; m_en = 0; m_mask = 0; m_pend = 0; m_rdata = 0;
        end else begin
            if (bus_rd && !bus_wr) begin
                case (int'(bus_addr))
                    'h00: m_rdata = m_mode;
                    'h0C: m_rdata = m_en;
                    'h18: m_rdata = m_mask;
                    'h1C: begin m_rdata = m_pend; ack = 1; end
                    default: m_rdata = 0;
                endcase
            end
            if (bus_wr) begin
                case (int'(bus_addr))
                    'h00: m_mode = wd;
                    'h04: m_en   = m_en | (wd & lim);
                    'h08: m_en   = m_en & ~wd;
                    'h10: m_mask = m_mask | (wd & lim);
                    'h14: m_mask = m_mask & ~wd;
                    default: ;
                endcase
            end
            if (ack) m_pend = 0;
            m_pend = m_pend | int'(period_end);
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (m_live) begin
            check("R2 ch_enable vs model", int'(ch_enable), m_en);
            check("R6 irq vs model", int'(irq), int'((m_pend & m_mask) != 0));
            check("R8 rdata vs model", bus_rdata, m_rdata);
        end
    end

    task automatic wr(input int a, input int unsigned d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, input int unsigned exp, input string tag);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse(input int unsigned bits);
        @(negedge clk);
        period_end = NCH'(bits);
        @(negedge clk);
        period_end = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ch_enable after reset", int'(ch_enable), 0);
        check("R1 irq after reset", int'(irq), 0);
        check("R1 rdata after reset", bus_rdata, 0);
        m_live = 1;
        rd('h0C, 0, "R1 status after reset");
        rd('h18, 0, "R1 mask after reset");
        rd('h1C, 0, "R1 pending after reset");

        wr('h04, 'h5);
        check("R2 enable set 0101", int'(ch_enable), 'h5);
        wr('h04, 'h2);
        check("R2 enable set keeps others", int'(ch_enable), 'h7);
        wr('h08, 'h1);
        check("R2 disable clears bit0", int'(ch_enable), 'h6);
        wr('h08, 'h0);
        check("R2 zero write no effect", int'(ch_enable), 'h6);
        rd('h0C, 'h6, "R8 status reads enables");
        wr('h04, 'hFFFF_FFF0);
        rd('h0C, 'h6, "R8 bits above NUM_CH ignored");

        wr('h10, 'h3);
        rd('h18, 'h3, "R3 mask set");
        wr('h14, 'h1);
        rd('h18, 'h2, "R3 mask clear");

        pulse('h1);
        check("R6 masked event no irq", int'(irq), 0);
        pulse('h2);
        check("R4 R6 unmasked event raises irq", int'(irq), 1);
        rd('h1C, 'h3, "R5 pending read value");
        check("R5 irq after ack", int'(irq), 0);
        rd('h1C, 'h0, "R5 pending cleared");

        // event in the same cycle as a status read
        @(negedge clk);
        bus_addr = AW'('h1C); bus_rd = 1'b1; period_end = 4'h4;
        @(negedge clk);
        bus_rd = 1'b0; period_end = '0;
        check("R5 overlap read returns old", bus_rdata, 0);
        rd('h1C, 'h4, "R5 overlap event kept");

        wr('h00, 'hA5A5_1234);
        rd('h00, 'hA5A5_1234, "R7 mode readback");

        wr('h18, 'hF);
        rd('h18, 'h2, "R8 mask register write ignored");
        wr('h0C, 'hF);
        rd('h0C, 'h6, "R8 status write ignored");
        rd('h40, 'h0, "R8 unmapped reads zero");

        // write and read together: read ignored, rdata holds
        @(negedge clk);
        bus_addr = AW'('h04); bus_wdata = 'h1; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R8 read ignored during write", bus_rdata, 0);
        check("R2 write during read applied", int'(ch_enable), 'h7);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule